// File: doc/BRIEF.md
# Serial NOR Flash Status and Write-Protect Controller

This block holds the status state of a small serial NOR flash device and decides whether each program, erase or status-write request may go ahead. An SPI front end that has already decoded the opcode drives it. The front end sends one-cycle strobes for write-enable, write-disable, status write, page program, erase and status read. With each program or erase it also sends the target byte address and, for erase, the erase size.

The controller keeps a write-enable flag, three protection-level bits, a top/bottom selector and a sector/block granularity selector. It works out a protected window of the array from these bits. It accepts a modifying request only when the enable flag is set and the request's aligned region stays clear of that window. An accepted request starts a busy countdown whose length depends on the operation. Every modifying request clears the enable flag, whether it was accepted or not. Non-volatile bits are modelled as values loaded at reset.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset, a status read returns 0x00: not busy, enable flag clear, no protection, TB=0, SEC=0.
- R2: When idle, `cmd_wren` sets the enable flag and `cmd_wrdi` clears it. No acceptance or rejection pulse is produced for either.
- R3: An accepted program, erase or status write clears the enable flag and holds BUSY at 1 for exactly its configured cycle count: T_PROG for a page, T_SECT for a 4 KB sector, T_BLK for a 32 KB or 64 KB block, T_CHIP for the whole array, T_WRSR for a status write.
- R4: A program, erase or status write issued while the enable flag is 0 is rejected. It pulses `req_rej`, BUSY stays 0 and the protection bits are unchanged.
- R5: The protected size is zero when the level field is 0 and the whole 512 KB array when it is 7. For levels 1 to 6 it is one unit shifted left by (level-1), capped at the array size. The unit is 64 KB when SEC=0 and 4 KB when SEC=1.
- R6: With TB=0 the window ends at the top address, and with TB=1 it starts at address 0. A program or erase is rejected when any byte of its size-aligned region falls inside the window; a rejection still clears the enable flag. Regions: program 256 B, `erase_kind` 0 = 4 KB, 1 = 32 KB, 2 = 64 KB, 3 = whole array.
- R7: A whole-array erase is rejected whenever the protection level is nonzero.
- R8: While BUSY is 1, every strobe other than status read is ignored. The enable flag and protection bits do not change, and no acceptance or rejection pulse appears.
- R9: `cmd_rdsr` produces `rd_valid` on the next cycle, with `rd_data` = {0, SEC, TB, level[2:0], WEL, BUSY} (bit 0 BUSY, bit 1 WEL, bits 4:2 level, bit 5 TB, bit 6 SEC, bit 7 zero). This holds even while busy.
- R10: An accepted status write loads SEC, TB and the level from `wrsr_data` bits 6, 5 and 4:2, and ignores bits 7, 1 and 0. Each modifying request produces exactly one of `req_ok` or `req_rej`, one cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_prog | input | 1 | Page-program strobe |
| cmd_erase | input | 1 | Erase strobe |
| cmd_rdsr | input | 1 | Status-read strobe |
| erase_kind | input | 2 | Erase size: 0 sector, 1 32 KB, 2 64 KB, 3 whole array |
| req_addr | input | 19 | Byte address of program or erase |
| wrsr_data | input | 8 | New status byte for a status write |
| req_ok | output | 1 | Pulse: modifying request accepted |
| req_rej | output | 1 | Pulse: modifying request rejected |
| rd_valid | output | 1 | Status byte valid |
| rd_data | output | 8 | Status byte |

## Verification
The hardest condition to reach is a strobe that arrives while an operation is still counting down. Random traffic almost never lines one up with that window, because the bench polls until idle after each command. A directed sequence therefore launches a page program with a long count, fires write-enable and a status write during the countdown with no status read in flight, and then counts the remaining busy reads and inspects the final byte. Protection edges are reached by loading each TB/SEC/level combination of interest and then probing the address on each side of the window boundary, for both program and erase sizes.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_PAGE,
      OP_SECT,
      OP_B32,
      OP_B64,
      OP_CHIP,
      OP_WRSR
   } flash_op_e;

   localparam int STAT_W = 8;

   function automatic int max_of5(input int a, input int b, input int c,
                                  input int d, input int e);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      if (e > m) m = e;
      return m;
   endfunction

endpackage

// File: rtl/flash_wp_range.sv
module flash_wp_range
   import flash_wp_pkg::*;
#(
   parameter int ARRAY_BYTES  = 524288,
   parameter int PAGE_BYTES   = 256,
   parameter int SECTOR_BYTES = 4096,
   parameter int HBLOCK_BYTES = 32768,
   parameter int BLOCK_BYTES  = 65536,
   localparam int AW          = $clog2(ARRAY_BYTES)
)(
   input  logic [2:0]    level,
   input  logic          from_bottom,
   input  logic          fine_grain,
   input  flash_op_e     op,
   input  logic [AW-1:0] addr,
   output logic          hit
);

   localparam int AWP = AW + 1;
   localparam int WW  = AW + 8;

   localparam logic [AW:0]   ARR_L  = AWP'(ARRAY_BYTES);
   localparam logic [WW-1:0] UNIT_S = WW'(SECTOR_BYTES);
   localparam logic [WW-1:0] UNIT_B = WW'(BLOCK_BYTES);
   localparam logic [WW-1:0] ARR_W  = WW'(ARRAY_BYTES);

   logic [WW-1:0] unit_w;
   logic [WW-1:0] grown_w;
   logic [AW:0]   win_size;
   logic [AW:0]   reg_len;
   logic [AW:0]   reg_start;
   logic [AW:0]   reg_end;
   logic [AW:0]   win_low;
   logic [AW-1:0] len_mask;

   // protected window size
   always_comb begin
      unit_w  = fine_grain ? UNIT_S : UNIT_B;
      grown_w = unit_w << (level - 3'd1);
      if (level == 3'd0)
         win_size = '0;
      else if (level == 3'd7 || grown_w >= ARR_W)
         win_size = ARR_L;
      else
         win_size = grown_w[AW:0];
   end

   // region touched by the request
   always_comb begin
      unique case (op)
         OP_PAGE: reg_len = AWP'(PAGE_BYTES);
         OP_SECT: reg_len = AWP'(SECTOR_BYTES);
         OP_B32:  reg_len = AWP'(HBLOCK_BYTES);
         OP_B64:  reg_len = AWP'(BLOCK_BYTES);
         default: reg_len = ARR_L;
      endcase
      len_mask  = ~(reg_len[AW-1:0] - AW'(1));
      reg_start = {1'b0, addr & len_mask};
      reg_end   = reg_start + reg_len;
      win_low   = ARR_L - win_size;
   end

   always_comb begin
      if (win_size == '0)
         hit = 1'b0;
      else if (from_bottom)
         hit = reg_start < win_size;
      else
         hit = reg_end > win_low;
   end

endmodule

// File: rtl/flash_wp_timer.sv
module flash_wp_timer #(
   parameter int CNT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] dur,
   output logic             busy
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= dur;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign busy = (cnt_q != '0);

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
   import flash_wp_pkg::*;
#(
   parameter int ARRAY_BYTES  = 524288,
   parameter int PAGE_BYTES   = 256,
   parameter int SECTOR_BYTES = 4096,
   parameter int HBLOCK_BYTES = 32768,
   parameter int BLOCK_BYTES  = 65536,
   parameter int T_PROG       = 64,
   parameter int T_SECT       = 200,
   parameter int T_BLK        = 400,
   parameter int T_CHIP       = 1000,
   parameter int T_WRSR       = 40,
   localparam int AW          = $clog2(ARRAY_BYTES)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_wren,
   input  logic          cmd_wrdi,
   input  logic          cmd_wrsr,
   input  logic          cmd_prog,
   input  logic          cmd_erase,
   input  logic          cmd_rdsr,
   input  logic [1:0]    erase_kind,
   input  logic [AW-1:0] req_addr,
   input  logic [7:0]    wrsr_data,
   output logic          req_ok,
   output logic          req_rej,
   output logic          rd_valid,
   output logic [7:0]    rd_data
);

   localparam int T_MAX = max_of5(T_PROG, T_SECT, T_BLK, T_CHIP, T_WRSR);
   localparam int CNT_W = $clog2(T_MAX + 1);

   // elaboration checks
   if ((ARRAY_BYTES & (ARRAY_BYTES - 1)) != 0) begin : g_bad_array
      $error("ARRAY_BYTES must be a power of two");
   end
   if (BLOCK_BYTES > ARRAY_BYTES || HBLOCK_BYTES > BLOCK_BYTES ||
       SECTOR_BYTES > HBLOCK_BYTES || PAGE_BYTES > SECTOR_BYTES) begin : g_bad_sizes
      $error("region sizes must nest page <= sector <= half block <= block <= array");
   end
   if (T_PROG < 1 || T_SECT < 1 || T_BLK < 1 || T_CHIP < 1 || T_WRSR < 1) begin : g_bad_time
      $error("every busy count must be at least one cycle");
   end

   logic       wel_q;
   logic [2:0] bp_q;
   logic       tb_q;
   logic       sec_q;
   logic       busy_w;

   flash_op_e        op;
   logic             is_mod;
   logic             in_window;
   logic             deny;
   logic             accept;
   logic             reject;
   logic [CNT_W-1:0] dur;
   logic [7:0]       status;
   logic             unused_wrsr_bits;

   assign unused_wrsr_bits = ^{wrsr_data[7], wrsr_data[1:0]};

   // request classification
   always_comb begin
      op = OP_NONE;
      if (cmd_wrsr)
         op = OP_WRSR;
      else if (cmd_prog)
         op = OP_PAGE;
      else if (cmd_erase) begin
         unique case (erase_kind)
            2'd0:    op = OP_SECT;
            2'd1:    op = OP_B32;
            2'd2:    op = OP_B64;
            default: op = OP_CHIP;
         endcase
      end
   end

   flash_wp_range #(
      .ARRAY_BYTES  (ARRAY_BYTES),
      .PAGE_BYTES   (PAGE_BYTES),
      .SECTOR_BYTES (SECTOR_BYTES),
      .HBLOCK_BYTES (HBLOCK_BYTES),
      .BLOCK_BYTES  (BLOCK_BYTES)
   ) u_range (
      .level       (bp_q),
      .from_bottom (tb_q),
      .fine_grain  (sec_q),
      .op          (op),
      .addr        (req_addr),
      .hit         (in_window)
   );

   always_comb begin
      is_mod = (op != OP_NONE);
      deny   = !wel_q ||
               (op != OP_WRSR && (in_window || (op == OP_CHIP && bp_q != 3'd0)));
      accept = !busy_w && is_mod && !deny;
      reject = !busy_w && is_mod && deny;
      unique case (op)
         OP_PAGE:       dur = CNT_W'(T_PROG);
         OP_SECT:       dur = CNT_W'(T_SECT);
         OP_B32, OP_B64: dur = CNT_W'(T_BLK);
         OP_CHIP:       dur = CNT_W'(T_CHIP);
         default:       dur = CNT_W'(T_WRSR);
      endcase
      status = {1'b0, sec_q, tb_q, bp_q, wel_q, busy_w};
   end

   flash_wp_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .dur   (dur),
      .busy  (busy_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q    <= 1'b0;
         bp_q     <= 3'd0;
         tb_q     <= 1'b0;
         sec_q    <= 1'b0;
         req_ok   <= 1'b0;
         req_rej  <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         req_ok   <= accept;
         req_rej  <= reject;
         rd_valid <= cmd_rdsr;
         if (cmd_rdsr)
            rd_data <= status;
         if (!busy_w) begin
            if (is_mod || cmd_wrdi)
               wel_q <= 1'b0;
            else if (cmd_wren)
               wel_q <= 1'b1;
            if (accept && op == OP_WRSR) begin
               sec_q <= wrsr_data[6];
               tb_q  <= wrsr_data[5];
               bp_q  <= wrsr_data[4:2];
            end
         end
      end
   end

endmodule

// File: rtl/flash_wp_ctrl_chk.sv
module flash_wp_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_wren,
   input logic       cmd_wrdi,
   input logic       cmd_wrsr,
   input logic       cmd_prog,
   input logic       cmd_erase,
   input logic       cmd_rdsr,
   input logic       req_ok,
   input logic       req_rej,
   input logic       rd_valid,
   input logic       rd_top,
   input logic       wel_q,
   input logic [2:0] bp_q,
   input logic       tb_q,
   input logic       sec_q,
   input logic       busy_w
);

   // input contract: one decoded command per cycle
   cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_wren, cmd_wrdi, cmd_wrsr, cmd_prog, cmd_erase, cmd_rdsr}));

   // R2
   wren_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wren && !busy_w && !cmd_wrdi && !cmd_wrsr && !cmd_prog && !cmd_erase)
      |=> wel_q);

   // R3
   ok_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ok |-> (busy_w && !wel_q));

   // R4
   ok_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ok |-> $past(wel_q));

   // R4
   rej_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_rej |-> (!busy_w && !wel_q));

   // R8
   frozen_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_w |=> $stable({wel_q, bp_q, tb_q, sec_q}));

   // R8
   no_reply_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_w |=> (!req_ok && !req_rej));

   // R9
   rd_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !rd_top);

   // R10
   single_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ok && req_rej));

endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_wren  (cmd_wren),
   .cmd_wrdi  (cmd_wrdi),
   .cmd_wrsr  (cmd_wrsr),
   .cmd_prog  (cmd_prog),
   .cmd_erase (cmd_erase),
   .cmd_rdsr  (cmd_rdsr),
   .req_ok    (req_ok),
   .req_rej   (req_rej),
   .rd_valid  (rd_valid),
   .rd_top    (rd_data[7]),
   .wel_q     (wel_q),
   .bp_q      (bp_q),
   .tb_q      (tb_q),
   .sec_q     (sec_q),
   .busy_w    (busy_w)
);

// File: tb/tb_flash_wp_ctrl.sv
module tb_flash_wp_ctrl;

   localparam int ARR    = 524288;
   localparam int TP     = 20;
   localparam int TS     = 9;
   localparam int TB_    = 13;
   localparam int TC     = 21;
   localparam int TW     = 4;
   localparam int C_WREN = 0;
   localparam int C_WRDI = 1;
   localparam int C_WRSR = 2;
   localparam int C_PROG = 3;
   localparam int C_ERAS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0;
   logic        cmd_prog = 0, cmd_erase = 0, cmd_rdsr = 0;
   logic [1:0]  erase_kind = '0;
   logic [18:0] req_addr = '0;
   logic [7:0]  wrsr_data = '0;
   logic        req_ok, req_rej, rd_valid;
   logic [7:0]  rd_data;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   // bench model of the status state
   int m_wel = 0, m_bp = 0, m_tb = 0, m_sec = 0;

   always #10 clk = ~clk;

   flash_wp_ctrl #(
      .T_PROG (TP), .T_SECT (TS), .T_BLK (TB_), .T_CHIP (TC), .T_WRSR (TW)
   ) dut (
      .clk (clk), .rst_n (rst_n),
      .cmd_wren (cmd_wren), .cmd_wrdi (cmd_wrdi), .cmd_wrsr (cmd_wrsr),
      .cmd_prog (cmd_prog), .cmd_erase (cmd_erase), .cmd_rdsr (cmd_rdsr),
      .erase_kind (erase_kind), .req_addr (req_addr), .wrsr_data (wrsr_data),
      .req_ok (req_ok), .req_rej (req_rej), .rd_valid (rd_valid), .rd_data (rd_data)
   );

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int model_status();
      return (m_sec << 6) | (m_tb << 5) | (m_bp << 2) | (m_wel << 1);
   endfunction

   function automatic int region_len(input int c, input int k);
      if (c == C_PROG) return 256;
      case (k)
         0: return 4096;
         1: return 32768;
         2: return 65536;
         default: return ARR;
      endcase
   endfunction

   function automatic int op_time(input int c, input int k);
      if (c == C_WRSR) return TW;
      if (c == C_PROG) return TP;
      case (k)
         0: return TS;
         1, 2: return TB_;
         default: return TC;
      endcase
   endfunction

   function automatic int in_window(input int c, input int a, input int k);
      int unit, size, len, start;
      unit = (m_sec != 0) ? 4096 : 65536;
      if (m_bp == 0) size = 0;
      else if (m_bp == 7) size = ARR;
      else begin
         size = unit << (m_bp - 1);
         if (size > ARR) size = ARR;
      end
      if (c == C_ERAS && k == 3 && m_bp != 0) return 1;
      if (size == 0) return 0;
      len   = region_len(c, k);
      start = (a / len) * len;
      if (m_tb != 0) return (start < size) ? 1 : 0;
      return (start + len > ARR - size) ? 1 : 0;
   endfunction

   task automatic drive(input int c, input int a, input int k, input int d);
      case (c)
         C_WREN: cmd_wren = 1;
         C_WRDI: cmd_wrdi = 1;
         C_WRSR: cmd_wrsr = 1;
         C_PROG: cmd_prog = 1;
         default: cmd_erase = 1;
      endcase
      req_addr   = a[18:0];
      erase_kind = k[1:0];
      wrsr_data  = d[7:0];
   endtask

   task automatic release_cmds();
      cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_prog = 0; cmd_erase = 0;
   endtask

   // poll status every cycle until idle; returns busy cycle count and final byte
   task automatic poll_idle(output int ones, output int last);
      bit fin;
      ones = 0;
      fin = 0;
      last = 0;
      cmd_rdsr = 1;
      while (!fin) begin
         @(negedge clk);
         last = int'(rd_data);
         if (rd_data[0]) ones++;
         else fin = 1;
         if (ones > 5000) fin = 1;
      end
      cmd_rdsr = 0;
   endtask

   task automatic do_cmd(input int c, input int a, input int k, input int d,
                         input string tag);
      int exp_ok, exp_rej, exp_dur, ones, last;
      exp_ok = 0; exp_rej = 0; exp_dur = 0;
      if (c == C_WREN) m_wel = 1;
      else if (c == C_WRDI) m_wel = 0;
      else begin
         if (m_wel != 0 && (c == C_WRSR || in_window(c, a, k) == 0)) begin
            exp_ok  = 1;
            exp_dur = op_time(c, k);
            if (c == C_WRSR) begin
               m_sec = (d >> 6) & 1;
               m_tb  = (d >> 5) & 1;
               m_bp  = (d >> 2) & 7;
            end
         end else exp_rej = 1;
         m_wel = 0;
      end
      @(negedge clk);
      drive(c, a, k, d);
      @(negedge clk);
      release_cmds();
      chk({tag, " R10 req_ok"}, int'(req_ok), exp_ok);
      chk({tag, " R10 req_rej"}, int'(req_rej), exp_rej);
      poll_idle(ones, last);
      chk({tag, " R3 busy cycles"}, ones, exp_dur);
      chk({tag, " R9 status byte"}, last, model_status());
   endtask

   task automatic set_prot(input int bp, input int tb, input int sec);
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      do_cmd(C_WRSR, 0, 0, (sec << 6) | (tb << 5) | (bp << 2), "R10 wrsr");
   endtask

   initial begin
      int ones, last, r, a, k;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      chk("R1 req_ok", int'(req_ok), 0);
      poll_idle(ones, last);
      chk("R1 reset status", last, 0);
      chk("R1 rd_valid", int'(rd_valid), 1);

      // R2 enable / disable
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      do_cmd(C_WRDI, 0, 0, 0, "R2 wrdi");

      // R4 requests without enable
      do_cmd(C_PROG, 'h100, 0, 0, "R4 prog no wel");
      do_cmd(C_WRSR, 0, 0, 'h1C, "R4 wrsr no wel");
      do_cmd(C_ERAS, 'h0, 3, 0, "R4 chip no wel");

      // R3 each operation time, no protection
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      do_cmd(C_PROG, 'h1234, 0, 0, "R3 prog");
      for (int kk = 0; kk < 4; kk++) begin
         do_cmd(C_WREN, 0, 0, 0, "R2 wren");
         do_cmd(C_ERAS, 'h45678, kk, 0, "R3 erase");
      end

      // R10 ignored bits of status write
      set_prot(0, 0, 0);
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      do_cmd(C_WRSR, 0, 0, 'h83, "R10 ignored bits");

      // R5/R6 boundaries
      set_prot(1, 0, 1);
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      do_cmd(C_PROG, 'h7F000, 0, 0, "R6 top 4K inside");
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      do_cmd(C_PROG, 'h7EFFF, 0, 0, "R6 top 4K outside");
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      do_cmd(C_ERAS, 'h78000, 1, 0, "R6 32K overlap");
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      do_cmd(C_ERAS, 'h70000, 1, 0, "R6 32K clear");

      set_prot(2, 1, 1);
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      do_cmd(C_PROG, 'h1FFF, 0, 0, "R5 bottom 8K inside");
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      do_cmd(C_PROG, 'h2000, 0, 0, "R5 bottom 8K outside");

      set_prot(3, 0, 0);
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      do_cmd(C_PROG, 'h40000, 0, 0, "R5 top 256K inside");
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      do_cmd(C_PROG, 'h3FFFF, 0, 0, "R5 top 256K outside");

      set_prot(4, 0, 0);
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      do_cmd(C_PROG, 'h0, 0, 0, "R5 capped whole array");

      set_prot(6, 1, 1);
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      do_cmd(C_ERAS, 'h10000, 2, 0, "R5 128K bottom inside");
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      do_cmd(C_ERAS, 'h20000, 2, 0, "R5 128K bottom outside");

      set_prot(7, 1, 1);
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      do_cmd(C_PROG, 'h7FF00, 0, 0, "R5 level 7 all");

      // R7 whole-array erase
      set_prot(1, 1, 1);
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      do_cmd(C_ERAS, 'h7FFFF, 3, 0, "R7 chip with level");
      set_prot(0, 1, 1);
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      do_cmd(C_ERAS, 'h0, 3, 0, "R7 chip no level");

      // R8 strobes during busy are ignored
      do_cmd(C_WREN, 0, 0, 0, "R2 wren");
      @(negedge clk);
      drive(C_PROG, 'h300, 0, 0);
      @(negedge clk);
      release_cmds();
      chk("R8 prog accepted", int'(req_ok), 1);
      drive(C_WREN, 0, 0, 0);
      @(negedge clk);
      release_cmds();
      drive(C_WRSR, 0, 0, 'h7C);
      @(negedge clk);
      release_cmds();
      chk("R8 no reply while busy", int'(req_ok | req_rej), 0);
      m_wel = 0;
      poll_idle(ones, last);
      chk("R9 R3 busy reads", ones, TP - 2);
      chk("R8 status unchanged", last, model_status());

      // random traffic
      for (int it = 0; it < 250; it++) begin
         r = int'($urandom % 10);
         a = int'($urandom % ARR);
         k = int'($urandom % 4);
         if (r < 3) do_cmd(C_WREN, 0, 0, 0, "R2 rnd wren");
         else if (r == 3) do_cmd(C_WRDI, 0, 0, 0, "R2 rnd wrdi");
         else begin
            if (($urandom % 4) != 0) do_cmd(C_WREN, 0, 0, 0, "R2 rnd wren");
            if (r == 4) do_cmd(C_WRSR, 0, 0, int'($urandom % 256), "R10 rnd wrsr");
            else if (r < 7) do_cmd(C_PROG, a, 0, 0, "R6 rnd prog");
            else do_cmd(C_ERAS, a, k, 0, "R6 rnd erase");
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog R3 actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule